// File: doc/BRIEF.md
# Index Test-and-Branch Unit

This unit works out where the program goes next when a transfer-class instruction issues. It receives the current instruction location, the value of the register named by the instruction, a base and an index for the transfer address, and a three-bit operation code. One clock later it presents the next instruction location, a flag that shows whether the transfer was taken, and, when needed, a value and a write strobe for the named register.

The unit covers seven operations. Two are unconditional: a plain jump, and a jump that saves a return address. Two are counting loops that step the register down by one or by two and branch only while the count is not used up. Three are register tests: equal to zero, not zero, and non-negative in two's complement. Instruction addresses are 16 bits wide and wrap modulo 2^16, both when the transfer address is indexed and when the location steps past an instruction. The unit never changes the carry, overflow or excess indicators. It has no port for them.

Top module: `nxa_branch_unit`

## Requirements
- R1: While reset is asserted, and from reset until the first issue, `nxt_ilr`, `taken`, `h_we`, `h_wdata` and `done` are all zero.
- R2: `done` is high in exactly the cycle after a cycle in which `issue` was high. `h_we` is never high without `done`.
- R3: Op code 0 (jump) always branches to the transfer address and writes no register.
- R4: Op code 1 (link) writes the zero-extended address of the next instruction (`ilr` + 2, wrapped to 16 bits) to the register and branches to the transfer address.
- R5: Op code 2 (count down by one): if H is not zero, it writes H-1 and branches. If H is zero, it writes nothing and falls through.
- R6: Op code 3 (count down by two): if H, read as unsigned, is neither 0 nor 1, it writes H-2 and branches. Otherwise it writes nothing and falls through.
- R7: Op code 4 branches when H is zero. Op code 5 branches when H is not zero. Neither writes the register.
- R8: Op code 6 branches when bit 31 of H is 0, which means H is non-negative. It falls through when bit 31 is 1 and writes nothing.
- R9: The transfer address is (`z_base` + `z_index`) mod 2^16. The fall-through address is (`ilr` + 2) mod 2^16.
- R10: Op code 7 is reserved. It falls through and writes nothing.
- R11: In a cycle after one with `issue` low, `nxt_ilr` keeps its value and `done` and `h_we` are low.
- R12: On every `done` cycle with `h_we` low, `h_wdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously inside the unit |
| issue | input | 1 | Clock enable: the inputs below are captured on this edge |
| op | input | 3 | Operation code, 0 to 7 |
| ilr | input | 16 | Current instruction location |
| h_val | input | 32 | Value of the named register |
| z_base | input | 16 | Transfer address base |
| z_index | input | 16 | Transfer address index |
| nxt_ilr | output | 16 | Next instruction location |
| taken | output | 1 | The transfer was taken |
| h_we | output | 1 | Write strobe for the named register |
| h_wdata | output | 32 | Value to write to the named register |
| done | output | 1 | The results above belong to the previous issue |

## Verification
Every result comes out of one register stage. An operation presented with `issue` on one rising edge is visible on `done`, `nxt_ilr`, `taken`, `h_we` and `h_wdata` from that edge until the next one. The bench therefore drives inputs on a falling edge and lowers `issue` on the following falling edge. It samples and compares all outputs at that same moment, half a period after the capturing edge. Directed steps then hold `issue` low for several cycles to confirm that the results stay put and that `done` and `h_we` fall back to low, and they re-assert reset in mid-run to confirm that the outputs clear without waiting for a clock edge.

// File: rtl/nxa_pkg.sv
package nxa_pkg;

  typedef enum logic [2:0] {
    OP_JUMP  = 3'd0,
    OP_LINK  = 3'd1,
    OP_DEC1  = 3'd2,
    OP_DEC2  = 3'd3,
    OP_ZERO  = 3'd4,
    OP_NZERO = 3'd5,
    OP_NNEG  = 3'd6,
    OP_RSVD  = 3'd7
  } nxa_op_e;

  typedef enum logic [1:0] {
    WSRC_NONE = 2'd0,
    WSRC_LINK = 2'd1,
    WSRC_DEC  = 2'd2
  } nxa_wsrc_e;

endpackage

// File: rtl/nxa_rst_sync.sv
module nxa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/nxa_addr.sv
module nxa_addr #(
  parameter int ADDR_W    = 16,
  parameter int INSN_STEP = 2
) (
  input  logic [ADDR_W-1:0] ilr_i,
  input  logic [ADDR_W-1:0] zbase_i,
  input  logic [ADDR_W-1:0] zidx_i,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] seq_o
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(INSN_STEP);

  // Carry out of the top address bit is dropped in both sums.
  assign target_o = zbase_i + zidx_i;
  assign seq_o    = ilr_i + STEP_V;

endmodule

// File: rtl/nxa_cond.sv
module nxa_cond
  import nxa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] h_i,
  output logic              taken_o,
  output nxa_wsrc_e         wsrc_o,
  output logic [DATA_W-1:0] dec_o
);

  localparam logic [DATA_W-1:0] ONE_V = DATA_W'(1);
  localparam logic [DATA_W-1:0] TWO_V = DATA_W'(2);

  logic h_zero, h_one, h_neg;
  logic [DATA_W-1:0] dec_step;

  assign h_zero = (h_i == '0);
  assign h_one  = (h_i == ONE_V);
  assign h_neg  = h_i[DATA_W-1];

  always_comb begin
    taken_o  = 1'b0;
    wsrc_o   = WSRC_NONE;
    dec_step = ONE_V;
    unique case (nxa_op_e'(op_i))
      OP_JUMP:  taken_o = 1'b1;
      OP_LINK: begin
        taken_o = 1'b1;
        wsrc_o  = WSRC_LINK;
      end
      OP_DEC1: begin
        if (!h_zero) begin
          taken_o = 1'b1;
          wsrc_o  = WSRC_DEC;
        end
      end
      OP_DEC2: begin
        dec_step = TWO_V;
        if (!h_zero && !h_one) begin
          taken_o = 1'b1;
          wsrc_o  = WSRC_DEC;
        end
      end
      OP_ZERO:  taken_o = h_zero;
      OP_NZERO: taken_o = !h_zero;
      OP_NNEG:  taken_o = !h_neg;
      default:  taken_o = 1'b0;
    endcase
  end

  assign dec_o = h_i - dec_step;

endmodule

// File: rtl/nxa_branch_unit.sv
module nxa_branch_unit
  import nxa_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int INSN_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] ilr,
  input  logic [DATA_W-1:0] h_val,
  input  logic [ADDR_W-1:0] z_base,
  input  logic [ADDR_W-1:0] z_index,
  output logic [ADDR_W-1:0] nxt_ilr,
  output logic              taken,
  output logic              h_we,
  output logic [DATA_W-1:0] h_wdata,
  output logic              done
);

  localparam int PAD_W = DATA_W - ADDR_W;

  logic              rst_q_n;
  logic [ADDR_W-1:0] target, seq;
  logic              cond_taken;
  nxa_wsrc_e         wsrc;
  logic [DATA_W-1:0] dec_val, link_val;

  logic [ADDR_W-1:0] ilr_d, ilr_q;
  logic              tk_d, tk_q;
  logic              we_d, we_q;
  logic [DATA_W-1:0] wd_d, wd_q;
  logic              done_d, done_q;

  nxa_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  nxa_addr #(.ADDR_W(ADDR_W), .INSN_STEP(INSN_STEP)) u_addr (
    .ilr_i    (ilr),
    .zbase_i  (z_base),
    .zidx_i   (z_index),
    .target_o (target),
    .seq_o    (seq)
  );

  nxa_cond #(.DATA_W(DATA_W)) u_cond (
    .op_i    (op),
    .h_i     (h_val),
    .taken_o (cond_taken),
    .wsrc_o  (wsrc),
    .dec_o   (dec_val)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign link_val = {{PAD_W{1'b0}}, seq};
    end else begin : g_trunc
      assign link_val = seq[DATA_W-1:0];
    end
  endgenerate

  // Next-state logic
  always_comb begin
    ilr_d  = cond_taken ? target : seq;
    tk_d   = cond_taken;
    done_d = issue;
    we_d   = issue && (wsrc != WSRC_NONE);
    unique case (wsrc)
      WSRC_LINK: wd_d = link_val;
      WSRC_DEC:  wd_d = dec_val;
      default:   wd_d = '0;
    endcase
  end

  // Registers: the results are held while issue is low
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ilr_q <= '0;
      tk_q  <= 1'b0;
      wd_q  <= '0;
    end else if (issue) begin
      ilr_q <= ilr_d;
      tk_q  <= tk_d;
      wd_q  <= wd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      we_q   <= we_d;
    end
  end

  assign nxt_ilr = ilr_q;
  assign taken   = tk_q;
  assign h_we    = we_q;
  assign h_wdata = wd_q;
  assign done    = done_q;

  assert_we_needs_done_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    h_we |-> done);

  assert_done_after_issue_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    issue |=> done);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !issue |=> ($stable(nxt_ilr) && !done && !h_we));

  assert_taken_target_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && taken) |-> (nxt_ilr == ADDR_W'($past(z_base) + $past(z_index))));

  assert_fall_through_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && !taken) |-> (nxt_ilr == ADDR_W'($past(ilr) + ADDR_W'(INSN_STEP))));

  assert_dec2_guard_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && h_we && ($past(op) == 3'(OP_DEC2))) |-> ($past(h_val) > DATA_W'(1)));

  assert_quiet_wdata_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && !h_we) |-> (h_wdata == '0));

endmodule

// File: tb/sim_nxa_branch_unit.sv
module sim_nxa_branch_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [15:0] ilr;
    logic [31:0] h;
    logic [15:0] zb;
    logic [15:0] zi;
    logic [15:0] eilr;
    logic        et;
    logic        ewe;
    logic [31:0] ewd;
  } vec_t;

  // req, op, ilr, h, z_base, z_index, exp next, exp taken, exp we, exp wdata
  localparam vec_t VECS [NV] = '{
    '{4'd3,  3'd0, 16'h0010, 32'h00000005, 16'h0100, 16'h0004, 16'h0104, 1'b1, 1'b0, 32'h0},        // R3 jump
    '{4'd4,  3'd1, 16'h0200, 32'h00001234, 16'h0300, 16'h0000, 16'h0300, 1'b1, 1'b1, 32'h00000202}, // R4 link
    '{4'd4,  3'd1, 16'hFFFE, 32'h00000000, 16'h0010, 16'h0000, 16'h0010, 1'b1, 1'b1, 32'h00000000}, // R4 link wrap
    '{4'd5,  3'd2, 16'h0020, 32'h00000005, 16'h0040, 16'h0002, 16'h0042, 1'b1, 1'b1, 32'h00000004}, // R5
    '{4'd5,  3'd2, 16'h0020, 32'h00000000, 16'h0040, 16'h0002, 16'h0022, 1'b0, 1'b0, 32'h0},        // R5 exhausted
    '{4'd5,  3'd2, 16'h0020, 32'h80000000, 16'h0050, 16'h0000, 16'h0050, 1'b1, 1'b1, 32'h7FFFFFFF}, // R5 negative
    '{4'd6,  3'd3, 16'h0030, 32'h00000001, 16'h0060, 16'h0000, 16'h0032, 1'b0, 1'b0, 32'h0},        // R6 one
    '{4'd6,  3'd3, 16'h0030, 32'h00000002, 16'h0060, 16'h0000, 16'h0060, 1'b1, 1'b1, 32'h00000000}, // R6 two
    '{4'd6,  3'd3, 16'h0030, 32'h00000000, 16'h0060, 16'h0000, 16'h0032, 1'b0, 1'b0, 32'h0},        // R6 zero
    '{4'd6,  3'd3, 16'h0030, 32'hFFFFFFFF, 16'h0060, 16'h0000, 16'h0060, 1'b1, 1'b1, 32'hFFFFFFFD}, // R6 all ones
    '{4'd7,  3'd4, 16'h0040, 32'h00000000, 16'h0070, 16'h0000, 16'h0070, 1'b1, 1'b0, 32'h0},        // R7 zero taken
    '{4'd7,  3'd4, 16'h0040, 32'h00000001, 16'h0070, 16'h0000, 16'h0042, 1'b0, 1'b0, 32'h0},        // R7 zero not taken
    '{4'd7,  3'd5, 16'h0044, 32'h00000001, 16'h0080, 16'h0000, 16'h0080, 1'b1, 1'b0, 32'h0},        // R7 nonzero taken
    '{4'd7,  3'd5, 16'h0044, 32'h00000000, 16'h0080, 16'h0000, 16'h0046, 1'b0, 1'b0, 32'h0},        // R7 nonzero fall
    '{4'd8,  3'd6, 16'h0050, 32'h00000000, 16'h0090, 16'h0000, 16'h0090, 1'b1, 1'b0, 32'h0},        // R8 zero
    '{4'd8,  3'd6, 16'h0050, 32'h7FFFFFFF, 16'h0090, 16'h0000, 16'h0090, 1'b1, 1'b0, 32'h0},        // R8 max positive
    '{4'd8,  3'd6, 16'h0050, 32'h80000000, 16'h0090, 16'h0000, 16'h0052, 1'b0, 1'b0, 32'h0},        // R8 negative
    '{4'd10, 3'd7, 16'h0060, 32'h00000000, 16'h00A0, 16'h0000, 16'h0062, 1'b0, 1'b0, 32'h0},        // R10 reserved
    '{4'd9,  3'd0, 16'h0000, 32'h00000000, 16'hFFF0, 16'h0020, 16'h0010, 1'b1, 1'b0, 32'h0},        // R9 target wrap
    '{4'd9,  3'd4, 16'hFFFE, 32'h00000001, 16'h0100, 16'h0000, 16'h0000, 1'b0, 1'b0, 32'h0},        // R9 fall wrap
    '{4'd12, 3'd5, 16'h0070, 32'h00000000, 16'h0100, 16'h0000, 16'h0072, 1'b0, 1'b0, 32'h0}         // R12 wdata quiet
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [2:0]  op;
  logic [15:0] ilr, z_base, z_index, nxt_ilr;
  logic [31:0] h_val, h_wdata;
  logic        taken, h_we, done;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nxa_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .ilr(ilr), .h_val(h_val),
    .z_base(z_base), .z_index(z_index), .nxt_ilr(nxt_ilr), .taken(taken),
    .h_we(h_we), .h_wdata(h_wdata), .done(done)
  );

  task automatic check(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_vec(input vec_t v);
    check("nxt_ilr", int'(v.req), 32'(nxt_ilr), 32'(v.eilr));
    check("taken",   int'(v.req), 32'(taken),   32'(v.et));
    check("h_we",    int'(v.req), 32'(h_we),    32'(v.ewe));
    check("h_wdata", int'(v.req), h_wdata,      v.ewd);
    check("done",    2,           32'(done),    32'd1);          // R2
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t held;
    rst_n = 1'b0; issue = 1'b0; op = '0; ilr = '0; h_val = '0; z_base = '0; z_index = '0;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    check("reset nxt_ilr", 1, 32'(nxt_ilr), 32'd0);
    check("reset h_wdata", 1, h_wdata, 32'd0);
    check("reset flags", 1, 32'({taken, h_we, done}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("post-reset idle", 1, 32'({taken, h_we, done}), 32'd0);   // R1

    for (int i = 0; i < NV; i++) begin
      op = VECS[i].op; ilr = VECS[i].ilr; h_val = VECS[i].h;
      z_base = VECS[i].zb; z_index = VECS[i].zi; issue = 1'b1;
      @(negedge clk);
      issue = 1'b0;
      check_vec(VECS[i]);
    end

    // R2 / R11: after idle cycles, done and h_we drop and nxt_ilr holds
    op = 3'd1; ilr = 16'h0400; h_val = 32'h0; z_base = 16'h0500; z_index = 16'h0001; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    held = '{4'd4, 3'd1, 16'h0400, 32'h0, 16'h0500, 16'h0001, 16'h0501, 1'b1, 1'b1, 32'h00000402};
    check_vec(held);                                                  // R4
    op = 3'd0; z_base = 16'h1111; ilr = 16'h2222;                     // inputs change while idle
    @(negedge clk);
    check("idle done", 2, 32'(done), 32'd0);                          // R2
    check("idle h_we", 11, 32'(h_we), 32'd0);                         // R11
    repeat (3) @(negedge clk);
    check("idle hold nxt_ilr", 11, 32'(nxt_ilr), 32'h0501);           // R11
    check("idle hold taken", 11, 32'(taken), 32'd1);                  // R11

    // R1: reset asserted mid-run clears outputs without a clock edge
    op = 3'd2; h_val = 32'd9; z_base = 16'h0700; z_index = 16'h0; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("async reset nxt_ilr", 1, 32'(nxt_ilr), 32'd0);
    check("async reset wdata", 1, h_wdata, 32'd0);
    check("async reset flags", 1, 32'({taken, h_we, done}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("after reset release", 1, 32'({taken, h_we, done}), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule